// File: doc/BRIEF.md
# Start-Triggered Counting Sequencer

This block is a small controller-and-datapath pair. A two-bit state register with a decoder drives a 4-bit counter and two single-bit flags. The machine waits in an idle state until a start request arrives. It then clears the counter and the done flag, and counts upward once per clock.

On every count, the trace flag takes the value of counter bit 1, read before that cycle's increment. The count ends at the edge where counter bits 1 and 2 are both high. That edge moves the machine into a one-cycle finish state. The finish state raises the done flag and returns the machine to idle.

Each state's operations all take effect on the clock edge that closes the state. Decisions use the register values held during the state, not the values being written. The state is visible on three decoded strobes.

Top module: `asm_count_seq`

## Requirements
- R1: A synchronous reset puts the machine in idle (state code 00) with the counter, the trace flag and the done flag all at 0.
- R2: In idle with start low, the machine stays in idle, and the counter and both flags keep their values.
- R3: In idle with start high, the next edge moves to the count state (code 01), clears the counter and the done flag, and leaves the trace flag unchanged.
- R4: Each clock spent in the count state increments the counter by one, modulo 16.
- R5: Each clock spent in the count state loads the trace flag with counter bit 1 (the second least significant bit), taken before that cycle's increment.
- R6: From the count state, the machine moves to finish (code 11) when counter bits 1 and 2 are both 1 before the increment, and otherwise stays in count. After a launch this gives exactly seven count cycles, and the counter reaches 7.
- R7: The finish state lasts one cycle, sets the done flag, leaves the counter and the trace flag unchanged, and returns to idle.
- R8: Exactly one of the three state strobes (idle, count, finish) is high in every cycle after reset.
- R9: The start input has no effect outside the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Run request, sampled in idle |
| cnt | output | 4 | Counter value |
| flag_e | output | 1 | Trace flag, copy of counter bit 1 |
| flag_f | output | 1 | Done flag |
| st_idle | output | 1 | Idle state strobe |
| st_count | output | 1 | Count state strobe |
| st_done | output | 1 | Finish state strobe |

## Verification
Runs are launched after idle gaps of 0 to 5 cycles. Each launch tests both that idle holds its registers and that the launch clears the counter while the trace flag keeps the value left by the previous run. In some runs, start is held high through the whole count. This shows that start is ignored outside idle, and that the machine relaunches as soon as it is back in idle. The expected values for every count cycle are computed from the loop index. A mismatch therefore shows whether the trace flag uses the counter bit before or after the increment, and whether the exit happens one cycle early or late. A reset issued in the middle of a count confirms that the machine returns to its reset state from any point.

// File: rtl/asm_count_seq.sv
module asm_count_seq #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [CW-1:0] cnt,
  output logic          flag_e,
  output logic          flag_f,
  output logic          st_idle,
  output logic          st_count,
  output logic          st_done
);
  localparam int TB = 1;
  localparam int HB = 2;

  logic [1:0] g;
  logic [1:0] g_nx;

  assign st_idle  = (g == 2'b00);
  assign st_count = (g == 2'b01);
  assign st_done  = (g == 2'b11);

  assign g_nx[1] = st_count & cnt[TB] & cnt[HB];
  assign g_nx[0] = (st_idle & start) | st_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      g      <= 2'b00;
      cnt    <= '0;
      flag_e <= 1'b0;
      flag_f <= 1'b0;
    end else begin
      g <= g_nx;
      if (st_idle && start) begin
        cnt    <= '0;
        flag_f <= 1'b0;
      end
      if (st_count) begin
        cnt    <= cnt + 1'b1;
        flag_e <= cnt[TB];
      end
      if (st_done) flag_f <= 1'b1;
    end
  end

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $countones({st_idle, st_count, st_done}) == 1); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    st_idle && !start |=> st_idle && $stable(cnt) && $stable(flag_e) && $stable(flag_f)); // R2
  AST_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    st_idle && start |=> st_count && cnt == '0 && !flag_f && $stable(flag_e)); // R3
  AST_INC: assert property (@(posedge clk) disable iff (rst)
    st_count |=> cnt == CW'($past(cnt) + 1'b1)); // R4
  AST_TRACE: assert property (@(posedge clk) disable iff (rst)
    st_count |=> flag_e == $past(cnt[TB])); // R5
  AST_EXIT: assert property (@(posedge clk) disable iff (rst)
    st_count && cnt[TB] && cnt[HB] |=> st_done); // R6
  AST_STAY: assert property (@(posedge clk) disable iff (rst)
    st_count && !(cnt[TB] && cnt[HB]) |=> st_count); // R6
  AST_FINISH: assert property (@(posedge clk) disable iff (rst)
    st_done |=> st_idle && flag_f && $stable(cnt) && $stable(flag_e)); // R7
endmodule

// File: tb/asm_count_seq_test.sv
module asm_count_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] cnt;
  logic flag_e, flag_f, st_idle, st_count, st_done;
  int checks = 0;
  int errors = 0;
  logic e_now;

  always #5 clk = ~clk;

  asm_count_seq uut (
    .clk(clk), .rst(rst), .start(start), .cnt(cnt),
    .flag_e(flag_e), .flag_f(flag_f),
    .st_idle(st_idle), .st_count(st_count), .st_done(st_done)
  );

  // vector layout: {idle, count, done, e, f, cnt[3:0]}
  function automatic logic [8:0] vec(input logic [2:0] s, input logic e,
                                     input logic f, input logic [3:0] a);
    return {s, e, f, a};
  endfunction

  task automatic chk(input string req, input logic [8:0] exp);
    logic [8:0] act;
    act = {st_idle, st_count, st_done, flag_e, flag_f, cnt};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  // gap idle cycles, launch, follow whole run; hold keeps start high throughout
  task automatic run(input int gap, input logic hold);
    start = 1'b0;
    for (int i = 0; i < gap; i++) begin
      step();
      chk("R2", vec(3'b100, e_now, 1'b1, 4'd7));
    end
    start = 1'b1;
    step();
    chk("R3", vec(3'b010, e_now, 1'b0, 4'd0));
    if (!hold) start = 1'b0;
    for (int n = 0; n < 7; n++) begin
      step();
      if (n < 6) chk("R4 R5 R6 R9", vec(3'b010, n[1], 1'b0, 4'(n + 1)));
      else       chk("R6 R5", vec(3'b001, 1'b1, 1'b0, 4'd7));
    end
    step();
    chk("R7", vec(3'b100, 1'b1, 1'b1, 4'd7));
    e_now = 1'b1;
    start = 1'b0;
  endtask

  initial begin
    e_now = 1'b0;
    step(); step();
    chk("R1", vec(3'b100, 1'b0, 1'b0, 4'd0));
    rst = 1'b0;
    step();
    chk("R8 R2", vec(3'b100, 1'b0, 1'b0, 4'd0));
    start = 1'b1;
    step();
    chk("R3", vec(3'b010, 1'b0, 1'b0, 4'd0));
    start = 1'b0;
    for (int n = 0; n < 7; n++) begin
      step();
      if (n < 6) chk("R4 R5", vec(3'b010, n[1], 1'b0, 4'(n + 1)));
      else       chk("R6", vec(3'b001, 1'b1, 1'b0, 4'd7));
    end
    step();
    chk("R7", vec(3'b100, 1'b1, 1'b1, 4'd7));
    e_now = 1'b1;
    for (int gap = 0; gap < 6; gap++) run(gap, gap[0]);
    // back-to-back relaunch with start held high
    start = 1'b1;
    run(0, 1'b1);
    // reset in the middle of a count
    start = 1'b1;
    step();
    start = 1'b0;
    step(); step();
    chk("R4", vec(3'b010, 1'b0, 1'b0, 4'd2));
    rst = 1'b1;
    step();
    chk("R1", vec(3'b100, 1'b0, 1'b0, 4'd0));
    rst = 1'b0;
    step();
    chk("R2", vec(3'b100, 1'b0, 1'b0, 4'd0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule